// File: doc/BRIEF.md
# Write Buffer with Read Forwarding

This block sits between a write-through data cache and main memory. Every processor store goes into the cache and into this buffer in the same operation. The buffer keeps a small queue of pending writes and retires them to a single memory port, oldest first, whenever the memory is ready. The processor therefore does not wait for each store to reach memory.

Because a pending entry may be the only up-to-date copy of a location, every read miss is compared in parallel against all queued entries before memory is used. On a match the newest matching data is returned at once and memory is not read. On no match the read goes to memory in the same cycle and takes priority over draining. A read miss that evicts a dirty block can push that block into the buffer in the same cycle its memory read is issued, so the eviction costs no extra memory round trip before the refill.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the buffer is empty. `st_ready` and `vic_ready` are 1, `fwd_hit` is 0, and no memory write is requested.
- R2: An entry is accepted on any cycle with `st_valid && st_ready` or with `vic_valid && vic_ready`. Every accepted entry is written to memory exactly once, in acceptance order. A write completes on a cycle with `mem_req && mem_we && mem_ready`.
- R3: The buffer holds DEPTH entries (default 4). While it is full, `st_ready` and `vic_ready` are 0, and a held store is accepted only after an entry has drained.
- R4: A read (`rd_req`) that matches no queued entry drives `mem_req=1`, `mem_we=0` and `mem_addr=rd_addr` in that same cycle, with `fwd_hit=0` and `rd_ack=mem_ready`.
- R5: A read whose address equals a queued entry's address gives `fwd_hit=1` and `rd_ack=1` in that cycle, and issues no memory read.
- R6: When several queued entries match, `fwd_data` is the data of the most recently accepted one.
- R7: When a read goes to memory while entries are queued, the memory port carries the read (`mem_we=0`), and draining waits.
- R8: A victim entry has precedence over a store: `st_ready` is 0 while `vic_valid` is 1. A victim can be accepted in the same cycle that its read miss goes to memory, and from the next cycle on it forwards to reads of its address.
- R9: A drain write always presents the oldest queued entry. The entry stays queued, with the same address and data, until `mem_ready` is 1.
- R10: Once an entry has been written to memory, it no longer matches reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Processor store offered |
| st_addr | input | 16 | Store word address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store accepted this cycle when valid (stall when 0) |
| vic_valid | input | 1 | Dirty victim word offered |
| vic_addr | input | 16 | Victim word address |
| vic_data | input | 32 | Victim data |
| vic_ready | output | 1 | Victim accepted this cycle when valid |
| rd_req | input | 1 | Read miss lookup request |
| rd_addr | input | 16 | Read miss address |
| rd_ack | output | 1 | Read served this cycle (forwarded or taken by memory) |
| fwd_hit | output | 1 | Read matched a queued entry |
| fwd_data | output | 32 | Newest matching queued data |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = write (drain), 0 = read |
| mem_addr | output | 16 | Memory command address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the command this cycle |

## Verification
The assertions check the port-level rules on every cycle. These are the stall whenever the queue is full, victim precedence over stores, a miss going straight to memory ahead of any drain, no memory read when forwarding, and a waiting drain write being held unchanged. The bench's scenarios are needed for what a single cycle cannot show. That covers exact drain order, no entry lost or repeated across full-queue stalls, the newest-match choice among duplicate addresses, and entries ceasing to forward once they have drained.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    parameter int unsigned WB_AW = 16;
    parameter int unsigned WB_DW = 32;

    typedef logic [WB_AW-1:0] addr_t;
    typedef logic [WB_DW-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wb_entry_t;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_sel_e;

    function automatic wb_entry_t make_entry(input addr_t a, input data_t d);
        wb_entry_t e;
        e.addr = a;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  wb_entry_t                    push_entry,
    input  logic                         pop,
    output wb_entry_t                    ord [DEPTH],
    output logic [DEPTH-1:0]             ord_vld,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    wb_entry_t        slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                slot_q[tail_q] <= push_entry;
                tail_q         <= tail_q + 1'b1;
            end
            if (pop) begin
                head_q <= head_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Age-ordered view: position 0 is the oldest entry.
    for (genvar k = 0; k < DEPTH; k++) begin : g_ord
        logic [PTR_W-1:0] idx;
        assign idx        = head_q + PTR_W'(k);
        assign ord[k]     = slot_q[idx];
        assign ord_vld[k] = (CNT_W'(k) < cnt_q);
    end

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign occ   = cnt_q;

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  wb_entry_t        ord [DEPTH],
    input  logic [DEPTH-1:0] ord_vld,
    input  addr_t            rd_addr,
    output logic             hit,
    output data_t            hit_data
);
    logic [DEPTH-1:0] eq;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign eq[k] = ord_vld[k] && (ord[k].addr == rd_addr);
    end

    // Scan oldest to newest; a later match overrides, so the newest wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (eq[k]) begin
                hit      = 1'b1;
                hit_data = ord[k].data;
            end
        end
    end

endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic      rd_req,
    input  addr_t     rd_addr,
    input  logic      fwd_hit,
    input  logic      drain_vld,
    input  wb_entry_t head,
    input  logic      mem_ready,
    output logic      mem_req,
    output logic      mem_we,
    output addr_t     mem_addr,
    output data_t     mem_wdata,
    output logic      pop,
    output logic      rd_ack
);
    port_sel_e sel;

    always_comb begin
        if (rd_req && !fwd_hit) begin
            sel = PORT_READ;
        end else if (drain_vld) begin
            sel = PORT_DRAIN;
        end else begin
            sel = PORT_IDLE;
        end
    end

    always_comb begin
        mem_req   = (sel != PORT_IDLE);
        mem_we    = (sel == PORT_DRAIN);
        mem_addr  = (sel == PORT_READ) ? rd_addr : head.addr;
        mem_wdata = head.data;
        pop       = (sel == PORT_DRAIN) && mem_ready;
        rd_ack    = rd_req && (fwd_hit || ((sel == PORT_READ) && mem_ready));
    end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [WB_AW-1:0]  st_addr,
    input  logic [WB_DW-1:0]  st_data,
    output logic              st_ready,
    input  logic              vic_valid,
    input  logic [WB_AW-1:0]  vic_addr,
    input  logic [WB_DW-1:0]  vic_data,
    output logic              vic_ready,
    input  logic              rd_req,
    input  logic [WB_AW-1:0]  rd_addr,
    output logic              rd_ack,
    output logic              fwd_hit,
    output logic [WB_DW-1:0]  fwd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WB_AW-1:0]  mem_addr,
    output logic [WB_DW-1:0]  mem_wdata,
    input  logic              mem_ready
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    wb_entry_t        ord [DEPTH];
    logic [DEPTH-1:0] ord_vld;
    logic             full, empty, push, pop;
    logic [CNT_W-1:0] occ;
    wb_entry_t        in_entry;

    // Victim takes the single enqueue slot ahead of a store.
    assign vic_ready = !full;
    assign st_ready  = !full && !vic_valid;
    assign push      = (vic_valid && vic_ready) || (st_valid && st_ready);
    assign in_entry  = vic_valid ? make_entry(vic_addr, vic_data)
                                 : make_entry(st_addr, st_data);

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (in_entry),
        .pop        (pop),
        .ord        (ord),
        .ord_vld    (ord_vld),
        .full       (full),
        .empty      (empty),
        .occ        (occ)
    );

    wbuf_match #(.DEPTH(DEPTH)) u_match (
        .ord      (ord),
        .ord_vld  (ord_vld),
        .rd_addr  (rd_addr),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    wbuf_arb u_arb (
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .fwd_hit   (fwd_hit),
        .drain_vld (!empty),
        .head      (ord[0]),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pop       (pop),
        .rd_ack    (rd_ack)
    );

endmodule

// File: rtl/wbuf_fwd_chk.sv
module wbuf_fwd_chk
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       st_ready,
    input logic                       vic_valid,
    input logic                       vic_ready,
    input logic                       rd_req,
    input logic [WB_AW-1:0]           rd_addr,
    input logic                       fwd_hit,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic [WB_AW-1:0]           mem_addr,
    input logic [WB_DW-1:0]           mem_wdata,
    input logic                       mem_ready,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    p_empty_no_write_r1: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !(mem_req && mem_we));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) |-> (!st_ready && !vic_ready));

    p_miss_to_mem_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !fwd_hit) |-> (mem_req && (mem_addr == rd_addr)));

    p_fwd_no_read_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && fwd_hit) |-> !(mem_req && !mem_we));

    p_read_first_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !fwd_hit && (occ != '0)) |-> !mem_we);

    p_vic_first_r8: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> !st_ready);

    p_drain_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_ready) |=>
            (!(mem_req && mem_we) || ($stable(mem_addr) && $stable(mem_wdata))));

endmodule

bind wbuf_fwd wbuf_fwd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_ready  (st_ready),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .fwd_hit   (fwd_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .occ       (occ)
);

// File: tb/test_wbuf_fwd.sv
`timescale 1ns/1ps
module test_wbuf_fwd;

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0, vic_valid = 1'b0, rd_req = 1'b0, mready = 1'b0;
    logic [15:0] st_addr = '0, vic_addr = '0, rd_addr = '0;
    logic [31:0] st_data = '0, vic_data = '0;
    logic        st_ready, vic_ready, rd_ack, fwd_hit, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, fwd_data;

    int checks = 0;
    int failures = 0;
    ent_t pend[$];   // scoreboard: accepted entries not yet written

    always #10 clk = ~clk;  // 50 MHz

    wbuf_fwd i_wbuf_fwd (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .vic_valid(vic_valid), .vic_addr(vic_addr), .vic_data(vic_data), .vic_ready(vic_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .fwd_hit(fwd_hit), .fwd_data(fwd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares every cycle against the scoreboard, then updates it.
    always @(negedge clk) begin
        if (!rst) begin
            bit          exp_hit;
            logic [31:0] exp_d;
            exp_hit = 1'b0;
            exp_d   = '0;
            foreach (pend[i]) begin
                if (pend[i].a == rd_addr) begin
                    exp_hit = 1'b1;
                    exp_d   = pend[i].d;
                end
            end
            chk(vic_ready == (pend.size() < 4), "R3", "vic_ready", 64'(vic_ready), 64'(pend.size() < 4));
            chk(st_ready == (pend.size() < 4 && !vic_valid), "R3", "st_ready",
                64'(st_ready), 64'(pend.size() < 4 && !vic_valid));
            if (rd_req) begin
                if (exp_hit) begin
                    chk(fwd_hit && rd_ack, "R5", "hit/ack", {fwd_hit, rd_ack}, 2'b11);
                    chk(fwd_data == exp_d, "R6", "fwd_data", 64'(fwd_data), 64'(exp_d));
                    chk(!(mem_req && !mem_we), "R5", "no mem read", 64'(mem_req), 0);
                end else begin
                    chk(!fwd_hit, "R4", "fwd_hit", 64'(fwd_hit), 0);
                    chk(mem_req && !mem_we && mem_addr == rd_addr, "R4", "mem read addr",
                        64'(mem_addr), 64'(rd_addr));
                    chk(rd_ack == mready, "R4", "rd_ack", 64'(rd_ack), 64'(mready));
                end
            end else begin
                chk((mem_req && mem_we) == (pend.size() > 0), "R2", "drain request",
                    64'(mem_req && mem_we), 64'(pend.size() > 0));
            end
            if (mem_req && mem_we) begin
                if (pend.size() == 0) begin
                    chk(1'b0, "R2", "write with empty queue", 64'(mem_addr), 0);
                end else begin
                    chk(mem_addr == pend[0].a && mem_wdata == pend[0].d, "R9", "drain head",
                        {mem_addr, mem_wdata}, {pend[0].a, pend[0].d});
                    if (mready) void'(pend.pop_front());
                end
            end
            if (vic_valid && vic_ready) pend.push_back('{a: vic_addr, d: vic_data});
            else if (st_valid && st_ready) pend.push_back('{a: st_addr, d: st_data});
        end
    end

    task automatic store(input logic [15:0] a, input logic [31:0] d);
        bit ok;
        @(posedge clk); #2;
        st_valid = 1'b1; st_addr = a; st_data = d;
        ok = 1'b0;
        while (!ok) begin
            @(negedge clk); ok = st_ready;
            @(posedge clk); #2;
        end
        st_valid = 1'b0;
    endtask

    task automatic read_start(input logic [15:0] a);
        @(posedge clk); #2;
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int n = 0; n < 60 && pend.size() != 0; n++) @(posedge clk);
        @(negedge clk);
        chk(pend.size() == 0, "R2", "queue drained", 64'(pend.size()), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(st_ready && vic_ready && !fwd_hit && !mem_req, "R1", "reset outputs",
            {st_ready, vic_ready, fwd_hit, mem_req}, 4'b1100);

        // Fill the queue while memory is not ready (R2, R3)
        store(16'h0010, 32'hAAAA0001);
        store(16'h0020, 32'hAAAA0002);
        store(16'h0010, 32'hAAAA0003);
        store(16'h0030, 32'hAAAA0004);
        @(posedge clk); #2;
        st_valid = 1'b1; st_addr = 16'h0050; st_data = 32'hAAAA0005;  // held while full
        @(negedge clk);
        chk(!st_ready, "R3", "full stalls store", 64'(st_ready), 0);

        // R6: duplicate address, newest wins
        read_start(16'h0010);
        chk(fwd_hit && fwd_data == 32'hAAAA0003, "R6", "newest match", 64'(fwd_data), 64'hAAAA0003);
        // R7: a miss takes the port ahead of the pending drain
        read_start(16'h0040);
        chk(mem_req && !mem_we && mem_addr == 16'h0040, "R7", "read before drain",
            {mem_we, mem_addr}, {1'b0, 16'h0040});
        // R5: single match forwarded
        read_start(16'h0030);
        chk(fwd_hit && fwd_data == 32'hAAAA0004 && rd_ack, "R5", "forward", 64'(fwd_data), 64'hAAAA0004);
        @(posedge clk); #2 rd_req = 1'b0;
        @(negedge clk);
        chk(mem_req && mem_we && mem_addr == 16'h0010 && mem_wdata == 32'hAAAA0001, "R9",
            "drain oldest", {mem_addr, mem_wdata}, {16'h0010, 32'hAAAA0001});
        @(negedge clk);
        chk(mem_we && mem_addr == 16'h0010 && mem_wdata == 32'hAAAA0001, "R9",
            "held while not ready", {mem_addr, mem_wdata}, {16'h0010, 32'hAAAA0001});

        // Let memory accept; the held store then enters (R3)
        @(posedge clk); #2 mready = 1'b1;
        begin
            bit ok;
            ok = 1'b0;
            while (!ok) begin
                @(negedge clk); ok = st_ready;
                @(posedge clk); #2;
            end
            st_valid = 1'b0;
        end
        wait_empty();

        // R10: drained entries no longer forward
        read_start(16'h0020);
        chk(!fwd_hit && mem_req && !mem_we, "R10", "drained not matched",
            {fwd_hit, mem_we}, 2'b00);

        // R8: victim parked while its read miss goes to memory
        @(posedge clk); #2;
        mready = 1'b0;
        rd_req = 1'b1; rd_addr = 16'h0070;
        vic_valid = 1'b1; vic_addr = 16'h0060; vic_data = 32'hBBBB0006;
        st_valid = 1'b1; st_addr = 16'h0080; st_data = 32'hCCCC0008;
        @(negedge clk);
        chk(vic_ready && !st_ready && mem_req && !mem_we && mem_addr == 16'h0070, "R8",
            "victim with read miss", {vic_ready, st_ready, mem_addr}, {1'b1, 1'b0, 16'h0070});
        @(posedge clk); #2;
        vic_valid = 1'b0; rd_addr = 16'h0060;
        @(negedge clk);
        chk(fwd_hit && fwd_data == 32'hBBBB0006, "R8", "victim forwards", 64'(fwd_data), 64'hBBBB0006);
        @(posedge clk); #2;
        st_valid = 1'b0; rd_req = 1'b0; mready = 1'b1;
        wait_empty();

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule